// File: doc/BRIEF.md
# Processor Interrupt Pin Conditioner

This block sits between a group of raw control pins and a processor core. It passes every pin through a synchronizer and remembers the last level it saw on each pin. It reacts only when a synchronized level differs from that stored level. Depending on which pin changed, it sets or clears a pending-interrupt bit, halts or resumes the core, or emits a one-cycle core reset request. Each pin has its own sense: active-high level, active-low level, or falling edge.

The core sees a pending vector, plus a summary request that is high while any pending bit is set. The core can drop pending bits with a clear strobe and a bit mask. A pin event in the same cycle as a clear wins over the clear. Pin positions above the six defined ones are still sampled and stored, but they have no effect.

Top module: `irq_pin_cond`

## Requirements
- R1: A synchronized pin whose level equals its stored level produces no event. Repeating a level, or clearing a level-driven bit while its pin stays high, does not change the pending vector, the halt state or the reset output.
- R2: pin_in[0] (external) drives pend[0], and pin_in[1] (system management) drives pend[1]. Each pin is active-high and level sensitive: the bit becomes 1 when the pin rises and 0 when it falls.
- R3: A 1-to-0 transition on pin_in[2] (machine check) sets pend[2]. A 0-to-1 transition has no effect. The bit stays set until the core clears it.
- R4: A falling level on pin_in[3] (checkstop, active low) sets halt to 1. A rising level sets halt back to 0.
- R5: A falling level on pin_in[4] (hard reset, active low) makes core_reset high for exactly one cycle. A rising level makes no pulse.
- R6: pin_in[5] (soft reset) drives pend[3] at its level, in the same way as R2.
- R7: irq_req is 1 exactly when at least one pend bit is 1.
- R8: Pin positions 6 and above are stored but change neither pend, halt nor core_reset.
- R9: A pin change driven before clock edge 1 shows on the outputs after edge 3 and not before. After reset, pend, halt, core_reset and every stored level are 0.
- R10: When clr_valid is high at an edge, the pend bits selected by clr_mask become 0 at that edge. If a pin event that sets a bit occurs at the same edge, the bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NUM_PINS | Raw asynchronous pins; the bit map is given in R2 to R6 |
| clr_valid | input | 1 | Core-side clear strobe |
| clr_mask | input | 4 | Pend bits to clear when clr_valid is high |
| pend | output | 4 | Pending bits: 0 external, 1 system management, 2 machine check, 3 soft reset |
| irq_req | output | 1 | Summary request: any pend bit set |
| halt | output | 1 | Core halt request |
| core_reset | output | 1 | One-cycle core reset request |

## Verification
A raw pin change passes two synchronizer flops and then the event register, so pend, halt and core_reset all move at the third rising edge after the change. irq_req follows pend in the same cycle. The bench drives pins on a falling edge and samples three falling edges later. In one test it also samples one edge early, to confirm the old value still holds. A clear strobe acts at the first edge after it is driven. For the priority test, the clear is therefore raised on the falling edge just before the third edge, so that it lands in the same cycle as the pin event.

// File: rtl/irq_pin_cond_pkg.sv
package irq_pin_cond_pkg;
  localparam int PEND_W  = 4;
  localparam int KNOWN_W = 6;

  // pin positions
  localparam int PIN_EXT    = 0;
  localparam int PIN_SMI    = 1;
  localparam int PIN_MCHK   = 2;
  localparam int PIN_CSTOP  = 3;
  localparam int PIN_HRESET = 4;
  localparam int PIN_SRESET = 5;

  // pending bit positions
  localparam int PND_EXT  = 0;
  localparam int PND_SMI  = 1;
  localparam int PND_MCHK = 2;
  localparam int PND_SRST = 3;

  // Next pending vector: the clear applies first, then pin events override it.
  function automatic logic [PEND_W-1:0] pend_next(
    input logic [PEND_W-1:0]  cur,
    input logic               clr_en,
    input logic [PEND_W-1:0]  clr_mask,
    input logic [KNOWN_W-1:0] lvl,
    input logic [KNOWN_W-1:0] rise,
    input logic [KNOWN_W-1:0] fall
  );
    logic [PEND_W-1:0] nxt;
    nxt = clr_en ? (cur & ~clr_mask) : cur;
    if (rise[PIN_EXT] | fall[PIN_EXT])       nxt[PND_EXT]  = lvl[PIN_EXT];
    if (rise[PIN_SMI] | fall[PIN_SMI])       nxt[PND_SMI]  = lvl[PIN_SMI];
    if (fall[PIN_MCHK])                      nxt[PND_MCHK] = 1'b1;
    if (rise[PIN_SRESET] | fall[PIN_SRESET]) nxt[PND_SRST] = lvl[PIN_SRESET];
    return nxt;
  endfunction
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= (s == 0) ? d : stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_pin_detect.sv
module irq_pin_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise_ev,
  output logic [W-1:0] fall_ev
);
  logic [W-1:0] last_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_lvl <= '0;
    else        last_lvl <= lvl;
  end

  assign rise_ev = lvl & ~last_lvl;
  assign fall_ev = ~lvl & last_lvl;
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
  import irq_pin_cond_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_valid,
  input  logic [PEND_W-1:0]  clr_mask,
  input  logic [KNOWN_W-1:0] lvl,
  input  logic [KNOWN_W-1:0] rise_ev,
  input  logic [KNOWN_W-1:0] fall_ev,
  output logic [PEND_W-1:0]  pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_next(pend, clr_valid, clr_mask, lvl, rise_ev, fall_ev);
  end
endmodule

// File: rtl/irq_core_ctl.sv
module irq_core_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cstop_fall,
  input  logic cstop_rise,
  input  logic hreset_fall,
  output logic halt,
  output logic core_reset
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt       <= 1'b0;
      core_reset <= 1'b0;
    end else begin
      if (cstop_fall)      halt <= 1'b1;
      else if (cstop_rise) halt <= 1'b0;
      core_reset <= hreset_fall;
    end
  end
endmodule

// File: rtl/irq_pin_cond.sv
module irq_pin_cond
  import irq_pin_cond_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                clr_valid,
  input  logic [PEND_W-1:0]   clr_mask,
  output logic [PEND_W-1:0]   pend,
  output logic                irq_req,
  output logic                halt,
  output logic                core_reset
);
  logic [NUM_PINS-1:0] sync_lvl;
  logic [NUM_PINS-1:0] rise_ev;
  logic [NUM_PINS-1:0] fall_ev;

  irq_pin_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_lvl)
  );

  irq_pin_detect #(.W(NUM_PINS)) det_i (
    .clk(clk), .rst_n(rst_n), .lvl(sync_lvl),
    .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  irq_pend_reg pend_i (
    .clk(clk), .rst_n(rst_n),
    .clr_valid(clr_valid), .clr_mask(clr_mask),
    .lvl(sync_lvl[KNOWN_W-1:0]),
    .rise_ev(rise_ev[KNOWN_W-1:0]),
    .fall_ev(fall_ev[KNOWN_W-1:0]),
    .pend(pend)
  );

  irq_core_ctl ctl_i (
    .clk(clk), .rst_n(rst_n),
    .cstop_fall(fall_ev[PIN_CSTOP]),
    .cstop_rise(rise_ev[PIN_CSTOP]),
    .hreset_fall(fall_ev[PIN_HRESET]),
    .halt(halt),
    .core_reset(core_reset)
  );

  assign irq_req = |pend;
endmodule

// File: rtl/irq_pin_cond_chk.sv
module irq_pin_cond_chk
  import irq_pin_cond_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] rise_ev,
  input logic [NUM_PINS-1:0] fall_ev,
  input logic                clr_valid,
  input logic [PEND_W-1:0]   pend,
  input logic                halt,
  input logic                core_reset
);
  logic known_quiet;
  assign known_quiet = (rise_ev[KNOWN_W-1:0] == '0) && (fall_ev[KNOWN_W-1:0] == '0);

  assert_quiet_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (known_quiet && !clr_valid) |=> ($stable(pend) && $stable(halt) && !core_reset));

  assert_ext_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev[PIN_EXT] |=> pend[PND_EXT]);

  assert_mchk_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev[PIN_MCHK] |=> pend[PND_MCHK]);

  assert_halt_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev[PIN_CSTOP] |=> halt);

  assert_halt_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev[PIN_CSTOP] |=> !halt);

  assert_rst_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset |=> !core_reset);

  assert_rst_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev[PIN_HRESET] |=> core_reset);

  assert_srst_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev[PIN_SRESET] && !rise_ev[PIN_SRESET] |=> !pend[PND_SRST]);

  if (NUM_PINS > KNOWN_W) begin : g_spare
    assert_spare_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (known_quiet && !clr_valid &&
       (|rise_ev[NUM_PINS-1:KNOWN_W] || |fall_ev[NUM_PINS-1:KNOWN_W]))
      |=> ($stable(pend) && $stable(halt) && !core_reset));
  end
endmodule

bind irq_pin_cond irq_pin_cond_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .rise_ev(rise_ev), .fall_ev(fall_ev),
  .clr_valid(clr_valid), .pend(pend), .halt(halt), .core_reset(core_reset)
);

// File: tb/irq_pin_cond_tb_top.sv
module irq_pin_cond_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_in = 8'h00;
  logic       clr_valid = 1'b0;
  logic [3:0] clr_mask = 4'h0;
  logic [3:0] pend;
  logic       irq_req, halt, core_reset;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  irq_pin_cond dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .clr_valid(clr_valid),
    .clr_mask(clr_mask), .pend(pend), .irq_req(irq_req), .halt(halt),
    .core_reset(core_reset)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_fail = n_fail + 1;
      n_chk = n_chk + 1;
      $display("FAIL watchdog: actual cycles=%0d expected < 20000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(input string req, input logic [3:0] ep, input logic eh, input logic er);
    n_chk = n_chk + 1;
    if (pend !== ep || irq_req !== (|ep) || halt !== eh || core_reset !== er) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual pend=%b irq=%b halt=%b rst=%b expected pend=%b irq=%b halt=%b rst=%b",
               req, pend, irq_req, halt, core_reset, ep, |ep, eh, er);
    end
  endtask

  // {pins[7:0], clr, mask[3:0], exp_pend[3:0], exp_halt, exp_rst}
  localparam int NV = 18;
  localparam logic [18:0] VEC [NV] = '{
    {8'h00, 1'b0, 4'h0, 4'b0000, 1'b0, 1'b0},  // R9 idle after reset
    {8'h01, 1'b0, 4'h0, 4'b0001, 1'b0, 1'b0},  // R2 ext rise
    {8'h03, 1'b0, 4'h0, 4'b0011, 1'b0, 1'b0},  // R2 smi rise
    {8'h02, 1'b0, 4'h0, 4'b0010, 1'b0, 1'b0},  // R2 ext fall
    {8'h06, 1'b0, 4'h0, 4'b0010, 1'b0, 1'b0},  // R3 mchk rise ignored
    {8'h02, 1'b0, 4'h0, 4'b0110, 1'b0, 1'b0},  // R3 mchk fall sets
    {8'h02, 1'b1, 4'h4, 4'b0010, 1'b0, 1'b0},  // R10 clear mchk
    {8'h0A, 1'b0, 4'h0, 4'b0010, 1'b0, 1'b0},  // R4 cstop high
    {8'h02, 1'b0, 4'h0, 4'b0010, 1'b1, 1'b0},  // R4 cstop low halts
    {8'h0A, 1'b0, 4'h0, 4'b0010, 1'b0, 1'b0},  // R4 resume
    {8'h1A, 1'b0, 4'h0, 4'b0010, 1'b0, 1'b0},  // R5 hreset rise no pulse
    {8'h0A, 1'b0, 4'h0, 4'b0010, 1'b0, 1'b1},  // R5 hreset fall pulse
    {8'h0A, 1'b0, 4'h0, 4'b0010, 1'b0, 1'b0},  // R1 R5 repeat, pulse gone
    {8'h2A, 1'b0, 4'h0, 4'b1010, 1'b0, 1'b0},  // R6 sreset rise
    {8'hEA, 1'b0, 4'h0, 4'b1010, 1'b0, 1'b0},  // R8 spare pins
    {8'hC8, 1'b0, 4'h0, 4'b0000, 1'b0, 1'b0},  // R6 R7 all clear
    {8'hC9, 1'b1, 4'hF, 4'b0001, 1'b0, 1'b0},  // R10 clear then ext
    {8'hC9, 1'b1, 4'h1, 4'b0000, 1'b0, 1'b0}   // R1 clear level bit, no re-set
  };

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset", 4'b0000, 1'b0, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      pin_in    = VEC[i][18:11];
      clr_valid = VEC[i][10];
      clr_mask  = VEC[i][9:6];
      @(negedge clk);
      clr_valid = 1'b0;
      clr_mask  = 4'h0;
      @(negedge clk);
      @(negedge clk);
      check($sformatf("vector %0d (see R tag)", i), VEC[i][5:2], VEC[i][1], VEC[i][0]);
    end

    // R9 latency and R10 priority: ext rise meets a clear of bit 0 at the same edge
    @(negedge clk); pin_in = 8'hC8;
    repeat (3) @(negedge clk);
    check("R2 ext low", 4'b0000, 1'b0, 1'b0);
    pin_in = 8'hC9;
    @(negedge clk);
    @(negedge clk);
    check("R9 not yet", 4'b0000, 1'b0, 1'b0);
    clr_valid = 1'b1; clr_mask = 4'h1;
    @(negedge clk);
    clr_valid = 1'b0; clr_mask = 4'h0;
    check("R10 event wins", 4'b0001, 1'b0, 1'b0);

    // R10 / R3 mchk fall together with clear of bit 2
    pin_in = 8'hCD;
    repeat (3) @(negedge clk);
    check("R3 mchk high no set", 4'b0001, 1'b0, 1'b0);
    pin_in = 8'hC9;
    @(negedge clk);
    @(negedge clk);
    clr_valid = 1'b1; clr_mask = 4'h4;
    @(negedge clk);
    clr_valid = 1'b0; clr_mask = 4'h0;
    check("R3 R10 mchk over clear", 4'b0101, 1'b0, 1'b0);

    // R7 clear both leaves nothing pending
    clr_valid = 1'b1; clr_mask = 4'h5;
    @(negedge clk);
    clr_valid = 1'b0; clr_mask = 4'h0;
    check("R7 R10 summary drops", 4'b0000, 1'b0, 1'b0);

    // R4 halt, then reset mid-run
    pin_in = 8'hC1;
    repeat (3) @(negedge clk);
    check("R4 halt again", 4'b0000, 1'b1, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset clears", 4'b0000, 1'b0, 1'b0);
    pin_in = 8'h00;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 stored zero, no event", 4'b0000, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule